// File: doc/BRIEF.md
# One-hot steering tally counter

The block counts how many of its N single-bit inputs are high and presents the result as a one-hot vector of N+1 lines. Line k is high exactly when k inputs are high. The vector is produced by a chain of N identical steering stages, one per input. The chain starts from a seed in which only line 0 is high. A stage whose input bit is 0 forwards the vector unchanged. A stage whose input bit is 1 shifts the hot line up by one place, and its bottom line then takes a constant 0.

A mode parameter selects between a purely combinational output and a registered output. In registered mode, a synchronous active-high reset forces the output to the "zero inputs high" code. The block suits consumers that decode the count directly, such as threshold selection, majority voting or arbitration by count, and that would otherwise need a decoder after a binary popcount.

Top module: `steer_tally`

## Requirements
- R1: The index of the high output line equals the number of high bits in `bits_in`.
- R2: For every input pattern, exactly one output line is high.
- R3: When all inputs are 0, line 0 is high (output value 1).
- R4: When all N inputs are 1, line N is high (output bit N set, all others clear).
- R5: Raising any one input that is currently 0, with the others held, moves the hot line up by exactly one position, so the new output equals the old output shifted left by one bit.
- R6: In registered mode (`MODE = OUT_REG`), the output reflects the inputs sampled at the previous rising clock edge and holds its value between edges. In combinational mode (`MODE = OUT_COMB`), the output follows the inputs with no clock.
- R7: In registered mode, `rst` high at a rising edge sets the output to line 0 only (value 1), regardless of the inputs.
- R8: The block works with N = 1: input 0 gives output 2'b01, and input 1 gives output 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered output mode |
| rst | input | 1 | Synchronous active-high reset for the registered output |
| bits_in | input | N | Bits to be counted |
| onehot_out | output | N+1 | One-hot count; bit k high means k inputs are high |

## Verification
On every clock edge, the assertions check that the output is one-hot, that its index matches the popcount of the inputs (taking the one-cycle delay into account in registered mode), the all-zero and all-ones end points, and the reset value. Only the bench scenarios can show the per-bit step-up relation between neighbouring patterns. The same holds for the output holding between clock edges and for the N = 1 configuration. The bench sweeps every input pattern of a four-input block in both modes.

// File: rtl/tally_pkg.sv
package tally_pkg;

    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REG  = 1'b1
    } out_mode_e;

    // Bit set in the seed vector and in the reset value: "no inputs high".
    localparam int unsigned TALLY_BASE_LINE = 0;

endpackage

// File: rtl/tally_stage.sv
module tally_stage #(
    parameter int unsigned W = 5
) (
    input  logic         sel,
    input  logic [W-1:0] prev,
    output logic [W-1:0] next
);
    // Bottom line has no lower neighbour: constant 0 when stepping up.
    assign next[0] = sel ? 1'b0 : prev[0];

    for (genvar i = 1; i < W; i++) begin : g_line
        assign next[i] = sel ? prev[i-1] : prev[i];
    end
endmodule

// File: rtl/tally_chain.sv
module tally_chain
    import tally_pkg::*;
#(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] bits,
    output logic [N:0]   hot
);
    localparam int unsigned W = N + 1;
    localparam logic [W-1:0] SEED = W'(1) << TALLY_BASE_LINE;

    logic [W-1:0] tap [0:N];

    assign tap[0] = SEED;

    for (genvar k = 0; k < N; k++) begin : g_stage
        tally_stage #(.W(W)) u_stage (
            .sel  (bits[k]),
            .prev (tap[k]),
            .next (tap[k+1])
        );
    end

    assign hot = tap[N];
endmodule

// File: rtl/tally_outreg.sv
module tally_outreg
    import tally_pkg::*;
#(
    parameter int unsigned W    = 5,
    parameter out_mode_e   MODE = OUT_REG
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] RESET_VAL = W'(1) << TALLY_BASE_LINE;

    if (MODE == OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) q <= RESET_VAL;
            else     q <= d;
        end
    end else begin : g_comb
        assign q = d;
    end
endmodule

// File: rtl/steer_tally.sv
module steer_tally
    import tally_pkg::*;
#(
    parameter int unsigned N    = 4,
    parameter out_mode_e   MODE = OUT_REG
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] bits_in,
    output logic [N:0]   onehot_out
);
    localparam int unsigned W = N + 1;

    logic [W-1:0] chain_hot;

    tally_chain #(.N(N)) u_chain (
        .bits (bits_in),
        .hot  (chain_hot)
    );

    tally_outreg #(.W(W), .MODE(MODE)) u_out (
        .clk (clk),
        .rst (rst),
        .d   (chain_hot),
        .q   (onehot_out)
    );

    if (MODE == OUT_REG) begin : g_chk_reg
        p_count_r1: assert property (@(posedge clk) disable iff (rst)
            !rst |=> onehot_out[$countones($past(bits_in))]);
        p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
            !rst |=> ($countones(onehot_out) == 1));
        p_all_zero_r3: assert property (@(posedge clk) disable iff (rst)
            (!rst && bits_in == '0) |=> onehot_out[0]);
        p_all_ones_r4: assert property (@(posedge clk) disable iff (rst)
            (!rst && (&bits_in)) |=> onehot_out[N]);
        p_reset_zero_r7: assert property (@(posedge clk)
            rst |=> (onehot_out == W'(1)));
    end else begin : g_chk_comb
        p_count_r1: assert property (@(posedge clk) disable iff (rst)
            onehot_out[$countones(bits_in)]);
        p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
            $countones(onehot_out) == 1);
        p_all_zero_r3: assert property (@(posedge clk) disable iff (rst)
            (bits_in == '0) |-> onehot_out[0]);
        p_all_ones_r4: assert property (@(posedge clk) disable iff (rst)
            (&bits_in) |-> onehot_out[N]);
    end
endmodule

// File: tb/sim_steer_tally.sv
module sim_steer_tally;
    import tally_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] b0 = 4'hF;
    logic [3:0] b2 = 4'h0;
    logic [0:0] b1 = 1'b0;
    logic [4:0] o0, o2;
    logic [1:0] o1;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    steer_tally #(.N(4), .MODE(OUT_REG))  u0 (.clk(clk), .rst(rst), .bits_in(b0), .onehot_out(o0));
    steer_tally #(.N(1), .MODE(OUT_COMB)) u1 (.clk(clk), .rst(rst), .bits_in(b1), .onehot_out(o1));
    steer_tally #(.N(4), .MODE(OUT_COMB)) u2 (.clk(clk), .rst(rst), .bits_in(b2), .onehot_out(o2));

    function automatic int pop4(input logic [3:0] v);
        int c = 0;
        for (int i = 0; i < 4; i++) c += int'(v[i]);
        return c;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [4:0] prev_exp;
        logic [4:0] a;
        // R7: reset with all inputs high
        repeat (3) @(negedge clk);
        chk("R7 reset value", 32'(o0), 32'h1);
        rst = 1'b0;
        b0 = 4'h0;
        prev_exp = 5'h1;

        // Registered sweep: R1, R2, R6
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            b0 = 4'(v);
            #1;
            chk("R6 hold before edge", 32'(o0), 32'(prev_exp));
            @(negedge clk);
            chk("R1 reg index", 32'(o0), 32'(5'h1 << pop4(4'(v))));
            chk("R2 reg onehot", 32'($countones(o0)), 32'd1);
            if (v == 0)  chk("R3 reg all zero", 32'(o0), 32'h01);
            if (v == 15) chk("R4 reg all ones", 32'(o0), 32'h10);
            prev_exp = 5'h1 << pop4(4'(v));
        end

        // R7: reset mid-run overrides inputs
        @(negedge clk);
        rst = 1'b1;
        b0 = 4'hF;
        @(negedge clk);
        chk("R7 mid-run reset", 32'(o0), 32'h1);
        rst = 1'b0;
        @(negedge clk);
        chk("R6 after reset release", 32'(o0), 32'h10);

        // Combinational sweep: R1, R2, R3, R4, R6
        for (int v = 0; v < 16; v++) begin
            b2 = 4'(v);
            #1;
            chk("R1 comb index", 32'(o2), 32'(5'h1 << pop4(4'(v))));
            chk("R2 comb onehot", 32'($countones(o2)), 32'd1);
            if (v == 0)  chk("R3 comb all zero", 32'(o2), 32'h01);
            if (v == 15) chk("R4 comb all ones", 32'(o2), 32'h10);
        end

        // R5: raising one low input steps the hot line up by one
        for (int v = 0; v < 16; v++) begin
            for (int j = 0; j < 4; j++) begin
                if (((v >> j) & 1) == 0) begin
                    b2 = 4'(v);
                    #1;
                    a = o2;
                    b2 = 4'(v | (1 << j));
                    #1;
                    chk("R5 step up", 32'(o2), 32'(a << 1));
                end
            end
        end

        // R8: single-input configuration
        b1 = 1'b0;
        #1;
        chk("R8 N=1 zero", 32'(o1), 32'h1);
        b1 = 1'b1;
        #1;
        chk("R8 N=1 one", 32'(o1), 32'h2);
        b1 = 1'b0;
        #1;
        chk("R8 N=1 back to zero", 32'(o1), 32'h1);

        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule